// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous burst memory. A full address is captured from the external address bus whenever either of two active-low address strobes is sampled low on a rising clock edge. That capture always wins over a burst that is still running. After the capture, only the two least significant address bits move. The upper bits keep the captured value until the next capture.

On each later clock, an active-low advance input picks one of two actions. It either steps to the next address of the burst or holds the present address without ending the burst. A static order-select pin chooses between two orders. In wrapping linear order, the low bits count up modulo four from the start value. In interleaved order, the low bits equal the start value XOR the burst position. Either order may begin at any of the four start values.

Both outputs come straight from registers. The address and the 2-bit burst position change just after the clock edge that decides them. The memory array, the data path and the chip-enable decode sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: With `rst` high at a rising edge, the stored address and the burst position both become zero. This reset takes priority over the strobes and the advance input.
- R2: If `strb_cpu_n` or `strb_ctl_n` (or both) is low at a rising edge, the whole of `ext_addr` is captured and `burst_pos` becomes 0. Straight after that edge, `addr_out` equals the captured address. This holds whatever `adv_n` is doing and whatever burst was in progress.
- R3: With both strobes high and `adv_n` low at a rising edge (a step cycle), `burst_pos` rises by one modulo 4.
- R4: With both strobes high and `adv_n` high at a rising edge (a hold cycle), `addr_out` and `burst_pos` stay unchanged.
- R5: With `order_sel` = 0 (linear), `addr_out[1:0]` equals the start value plus `burst_pos`, modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R6: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals the start value XOR `burst_pos`. For example, a start of 10 gives 10, 11, 00, 01.
- R7: `addr_out[ADDR_W-1:2]` keeps its captured value through every step and hold cycle. On those cycles `ext_addr` has no effect on the output.
- R8: A step taken at the fourth address (`burst_pos` = 3) returns `burst_pos` to 0, and `addr_out` returns to the burst's first address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_cpu_n | input | 1 | Active-low address strobe, first source |
| strb_ctl_n | input | 1 | Active-low address strobe, second source |
| adv_n | input | 1 | Active-low advance; high holds the current address |
| order_sel | input | 1 | Static order select: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External word address captured on a strobe |
| addr_out | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Position within the burst (0 to 3) |

## Verification
The bench builds the block with its default 18-bit address. This leaves 16 upper bits, enough to load patterns such as all-ones and mixed hex values and to check that no step or wrap carries into them. The start values cover all four low-bit values across the two orders. The runs include strobe-driven restarts partway through a burst, holds placed between steps, and a reset that arrives together with an active strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Number of address bits that the burst sequence walks through
    localparam int BURST_W   = 2;
    localparam int BURST_LEN = 1 << BURST_W;

    typedef logic [BURST_W-1:0] bpos_t;

    // Kind of cycle decided at each rising edge
    typedef enum logic [1:0] {
        CYC_HOLD = 2'b00,
        CYC_STEP = 2'b01,
        CYC_LOAD = 2'b10
    } cyc_e;

    // Order in which the low bits are visited
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Captured start bits plus how far the burst has advanced
    typedef struct packed {
        bpos_t start;
        bpos_t pos;
    } burst_ctx_t;

    // Low address bits for a given start value, position and order
    function automatic bpos_t seq_lsb(input bpos_t start, input bpos_t pos, input order_e ord);
        bpos_t res;
        if (ord == ORD_INTERLEAVE) begin
            res = start ^ pos;
        end else begin
            res = bpos_t'(start + pos);
        end
        return res;
    endfunction

    // Next burst position, wrapping after the last address
    function automatic bpos_t next_pos(input bpos_t pos);
        return bpos_t'(pos + 1'b1);
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    input  logic adv_n,
    output cyc_e kind
);

    logic any_strobe;

    assign any_strobe = ~(strb_cpu_n & strb_ctl_n);

    // A strobe always outranks the advance input
    always_comb begin
        if (any_strobe) begin
            kind = CYC_LOAD;
        end else if (!adv_n) begin
            kind = CYC_STEP;
        end else begin
            kind = CYC_HOLD;
        end
    end

endmodule

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - BURST_W
)(
    input  logic              clk,
    input  logic              rst,
    input  cyc_e              kind,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [UP_W-1:0]   upper_q,
    output burst_ctx_t        ctx_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            ctx_q   <= '0;
        end else begin
            unique case (kind)
                CYC_LOAD: begin
                    upper_q     <= ext_addr[ADDR_W-1:BURST_W];
                    ctx_q.start <= ext_addr[BURST_W-1:0];
                    ctx_q.pos   <= '0;
                end
                CYC_STEP: begin
                    ctx_q.pos <= next_pos(ctx_q.pos);
                end
                default: begin
                end
            endcase
        end
    end

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_STEP) |=> (ctx_q.pos == bpos_t'($past(ctx_q.pos) + 1'b1))); // R3

    AST_HOLD_KEEPS_CTX: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_HOLD) |=> ($stable(ctx_q) && $stable(upper_q))); // R4

    AST_STEP_KEEPS_START: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_STEP) |=> ($stable(ctx_q.start) && $stable(upper_q))); // R7

endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - BURST_W
)(
    input  logic              order_sel,
    input  logic [UP_W-1:0]   upper_q,
    input  burst_ctx_t        ctx_q,
    output logic [ADDR_W-1:0] addr
);

    bpos_t lsb;

    assign lsb  = seq_lsb(ctx_q.start, ctx_q.pos, order_e'(order_sel));
    assign addr = {upper_q, lsb};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BURST_W-1:0] burst_pos
);

    localparam int UP_W = ADDR_W - BURST_W;

    cyc_e            kind;
    logic [UP_W-1:0] upper_q;
    burst_ctx_t      ctx_q;

    burst_cmd_decode u_decode (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .kind       (kind)
    );

    burst_ctx_reg #(.ADDR_W(ADDR_W)) u_ctx (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .ext_addr (ext_addr),
        .upper_q  (upper_q),
        .ctx_q    (ctx_q)
    );

    burst_order_calc #(.ADDR_W(ADDR_W)) u_order (
        .order_sel (order_sel),
        .upper_q   (upper_q),
        .ctx_q     (ctx_q),
        .addr      (addr_out)
    );

    assign burst_pos = ctx_q.pos;

    AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n || !strb_ctl_n) |=> ((addr_out == $past(ext_addr)) && (burst_pos == '0))); // R2

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu_n && strb_ctl_n) |=> $stable(addr_out[ADDR_W-1:BURST_W])); // R7

    AST_LINEAR_NEXT: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu_n && strb_ctl_n && !adv_n && !order_sel) |=>
        (order_sel || (addr_out[BURST_W-1:0] == bpos_t'($past(addr_out[BURST_W-1:0]) + 1'b1)))); // R5

    AST_INTERLEAVE_START: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu_n && strb_ctl_n && order_sel) |=>
        (!order_sel || ((addr_out[BURST_W-1:0] ^ burst_pos) == $past(addr_out[BURST_W-1:0] ^ burst_pos)))); // R6

    AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu_n && strb_ctl_n && !adv_n && (burst_pos == bpos_t'(BURST_LEN - 1))) |=>
        (burst_pos == '0)); // R8

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    localparam int AW = 18;

    // ctl = {strb_cpu_n, strb_ctl_n, adv_n, order_sel}
    typedef struct packed {
        logic [3:0]    ctl;
        logic [AW-1:0] ext;
        logic [AW-1:0] exp_a;
        logic [1:0]    exp_p;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        // linear bursts
        '{4'b0110, 18'h2A5C1, 18'h2A5C1, 2'd0},  // load via first strobe
        '{4'b1100, 18'h3FFFF, 18'h2A5C2, 2'd1},  // step, ext ignored (R7)
        '{4'b1100, 18'h00000, 18'h2A5C3, 2'd2},
        '{4'b1110, 18'h15555, 18'h2A5C3, 2'd2},  // hold
        '{4'b1100, 18'h00000, 18'h2A5C0, 2'd3},
        '{4'b1100, 18'h00000, 18'h2A5C1, 2'd0},  // wrap to first (R8)
        '{4'b1000, 18'h1234E, 18'h1234E, 2'd0},  // load via second strobe, adv low
        '{4'b1100, 18'h00000, 18'h1234F, 2'd1},
        '{4'b0010, 18'h00003, 18'h00003, 2'd0},  // both strobes, restart mid burst
        '{4'b1100, 18'h3FFFF, 18'h00000, 2'd1},  // R3 step count
        // interleaved bursts
        '{4'b0111, 18'h3C00E, 18'h3C00E, 2'd0},
        '{4'b1101, 18'h00000, 18'h3C00F, 2'd1},
        '{4'b1101, 18'h00000, 18'h3C00C, 2'd2},
        '{4'b1111, 18'h2AAAA, 18'h3C00C, 2'd2},  // hold
        '{4'b1101, 18'h00000, 18'h3C00D, 2'd3},
        '{4'b1101, 18'h00000, 18'h3C00E, 2'd0},  // wrap to first (R8)
        '{4'b1011, 18'h15557, 18'h15557, 2'd0},
        '{4'b1101, 18'h00000, 18'h15556, 2'd1},
        '{4'b1101, 18'h00000, 18'h15555, 2'd2},
        '{4'b1101, 18'h00000, 18'h15554, 2'd3}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strb_cpu_n = 1'b1;
    logic          strb_ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    burst_pos;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // 4 ns period: 250 MHz
    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .ext_addr   (ext_addr),
        .addr_out   (addr_out),
        .burst_pos  (burst_pos)
    );

    task automatic cycle(input logic r, input logic [3:0] ctl, input logic [AW-1:0] ext);
        @(negedge clk);
        rst        = r;
        strb_cpu_n = ctl[3];
        strb_ctl_n = ctl[2];
        adv_n      = ctl[1];
        order_sel  = ctl[0];
        ext_addr   = ext;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp_a, input logic [1:0] exp_p);
        checks++;
        if (addr_out !== exp_a || burst_pos !== exp_p) begin
            errors++;
            $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d",
                     req, addr_out, burst_pos, exp_a, exp_p);
        end
    endtask

    function automatic string tag_of(input logic [3:0] ctl);
        if (!ctl[3] || !ctl[2]) return "R2";
        if (ctl[1])             return "R4";
        if (ctl[0])             return "R6";
        return "R5";
    endfunction

    initial begin
        // R1: reset state
        cycle(1'b1, 4'b1110, '0);
        cycle(1'b1, 4'b1110, '0);
        check("R1 reset state", 18'h00000, 2'd0);

        // R3 and R5: step straight after reset, linear from start 00
        cycle(1'b0, 4'b1100, 18'h3FFFF);
        check("R3 step after reset", 18'h00001, 2'd1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            cycle(1'b0, VECS[i].ctl, VECS[i].ext);
            check(tag_of(VECS[i].ctl), VECS[i].exp_a, VECS[i].exp_p);
        end

        // R1: reset wins over an active strobe during a burst
        cycle(1'b0, 4'b0110, 18'h3FFFF);
        cycle(1'b0, 4'b1100, 18'h00000);
        cycle(1'b1, 4'b0000, 18'h12345);
        check("R1 reset over strobe", 18'h00000, 2'd0);

        // R4 and R7: long hold with a changing bus
        cycle(1'b0, 4'b1010, 18'h2A5C1);
        cycle(1'b0, 4'b1100, 18'h00000);
        for (int k = 0; k < 5; k++) begin
            cycle(1'b0, 4'b1110, AW'(k * 18'h0F0F3));
            check("R4 hold keeps address", 18'h2A5C2, 2'd1);
        end

        // R7 and R8: all-ones upper bits never see a carry, wrap returns to first
        cycle(1'b0, 4'b0110, 18'h3FFFF);
        check("R2 load all ones", 18'h3FFFF, 2'd0);
        cycle(1'b0, 4'b1100, 18'h00000);
        check("R7 no carry into upper", 18'h3FFFC, 2'd1);
        cycle(1'b0, 4'b1100, 18'h00000);
        check("R5 linear third", 18'h3FFFD, 2'd2);
        cycle(1'b0, 4'b1100, 18'h00000);
        check("R5 linear fourth", 18'h3FFFE, 2'd3);
        cycle(1'b0, 4'b1100, 18'h00000);
        check("R8 wrap to first", 18'h3FFFF, 2'd0);

        // R6: interleaved from start 01
        cycle(1'b0, 4'b1011, 18'h00001);
        cycle(1'b0, 4'b1101, 18'h00000);
        check("R6 interleave second", 18'h00000, 2'd1);
        cycle(1'b0, 4'b1101, 18'h00000);
        check("R6 interleave third", 18'h00003, 2'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule